// File: doc/BRIEF.md
# Four-Lane Polarization Product Scale and Offset Stage

This block conditions four parallel polarization product streams before they enter a vector accumulator. Lanes 0 to 3 carry the I, Q, U and V products in that order. Each lane receives a signed 16-bit integer sample, adds its own programmable offset, multiplies the sum by its own programmable gain, then rounds the result and saturates it into a signed 8-bit output word. The gain and offset let the useful bits of the product land in the part of the narrow output word that the accumulator keeps.

Samples arrive with a valid strobe and a last strobe that marks the final sample of a spectrum. Gains, offsets and the lane-set selection are written to pending copies through a simple write port. They are copied into the working set only when the last sample of a spectrum is accepted, so no spectrum is ever processed with two different settings. A selection input picks between full-Stokes operation, where all four lanes are live, and total-intensity operation, where only lanes 0 and 1 are live. Each lane keeps a sticky overflow flag that records saturation. The flag is cleared through the same write port.

Top module: `pol_scale_stage`

## Requirements
- R1: After reset, every lane gain is 1.0 (0x0001_0000), every offset is 0, full-Stokes operation is selected, `out_valid` and `out_last` are 0 and all overflow flags are 0.
- R2: For a live lane k with input x taken from `in_data[16k+15:16k]`, where x is a signed integer, the gain g is an unsigned 32-bit number with 16 fractional bits and the offset o is a signed 32-bit number with 16 fractional bits, the output is `sat(round((x*2^16 + o) * g / 2^32))`. It appears on `out_data[8k+7:8k]`.
- R3: Rounding is to nearest, and exact halves round toward positive infinity: 1.5 gives 2, -1.5 gives -1 and -0.5 gives 0.
- R4: Results above 127 are output as 127, and results below -128 are output as -128.
- R5: `ovf_flags[k]` sets in the same cycle that a saturated valid output of lane k appears. It then stays set until it is cleared.
- R6: A write of data d to address 8 clears each flag k for which d bit k is 1. A saturation in the same cycle keeps that flag set.
- R7: Write addresses 0 to 3 load the pending gain of lanes 0 to 3. Addresses 4 to 7 load the pending offset of lanes 0 to 3. Addresses 9 to 15 change nothing.
- R8: Pending gains, offsets and the `full_stokes` level are copied into the working set only on a cycle with `in_valid` and `in_last` both 1. That last sample still uses the old working set. A write in that same cycle waits for the next boundary.
- R9: While the working selection is total intensity (`full_stokes` sampled as 0), lanes 2 and 3 output 0 and never set their overflow flags. Lanes 0 and 1 are unaffected.
- R10: `out_valid` equals `in_valid` from 3 cycles earlier, and `out_last` equals `in_valid && in_last` from 3 cycles earlier. The data of a sample appears with its valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_stokes | input | 1 | Lane-set selection (1 = four lanes, 0 = lanes 0 and 1), sampled at the spectrum boundary |
| in_valid | input | 1 | Input sample valid |
| in_last | input | 1 | Last sample of a spectrum |
| in_data | input | 64 | Four signed 16-bit samples, lane k at bits 16k+15:16k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| out_valid | output | 1 | Output sample valid |
| out_last | output | 1 | Output last-of-spectrum |
| out_data | output | 32 | Four signed 8-bit results, lane k at bits 8k+7:8k |
| ovf_flags | output | 4 | Sticky per-lane saturation flags |

## Verification
Identity settings with small samples show whether the offset add, multiply and output alignment compute the right value, or only pass bits through. A half gain with odd samples of both signs separates the round-half-up rule from truncation and from rounding away from zero. Out-of-range samples and offsets of both signs test clamping and sticky flag setting, and show which bits a clear removes. Writes placed in the middle of a spectrum, at its last sample and to unused addresses, together with long constrained-random runs that switch the lane-set selection, show whether settings change only at boundaries and whether the disabled lanes stay silent.

// File: rtl/pol_scale_pkg.sv
package pol_scale_pkg;

  // Number of register stages between input and output.
  localparam int PIPE_DEPTH = 3;

  // Control word travelling alongside the lane data.
  typedef struct packed {
    logic valid;
    logic last;
  } ctl_t;

endpackage

// File: rtl/pol_ctrl_pipe.sv
module pol_ctrl_pipe
  import pol_scale_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctl_t                       ctl_in,
  output ctl_t [PIPE_DEPTH-1:0]      ctl_stage
);

  ctl_t [PIPE_DEPTH-1:0] stage_d;
  ctl_t [PIPE_DEPTH-1:0] stage_q;

  always_comb begin
    stage_d[0].valid = ctl_in.valid;
    stage_d[0].last  = ctl_in.valid & ctl_in.last;
  end

  for (genvar i = 1; i < PIPE_DEPTH; i++) begin : g_shift
    always_comb stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign ctl_stage = stage_q;

  // R10: a last marker never travels without its valid
  assert_last_has_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[PIPE_DEPTH-1].last |-> stage_q[PIPE_DEPTH-1].valid);

endmodule

// File: rtl/pol_cfg_regs.sv
module pol_cfg_regs #(
  parameter int LANES  = 4,
  parameter int COEF_W = 32,
  parameter int FRAC   = 16,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [COEF_W-1:0]             wr_data,
  input  logic                          boundary,
  input  logic                          mode_in,
  output logic [LANES-1:0][COEF_W-1:0]  act_gain,
  output logic [LANES-1:0][COEF_W-1:0]  act_off,
  output logic                          act_full
);

  localparam logic [COEF_W-1:0] GAIN_ONE = COEF_W'(1) << FRAC;

  logic [LANES-1:0][COEF_W-1:0] pend_gain_d, pend_gain_q;
  logic [LANES-1:0][COEF_W-1:0] pend_off_d,  pend_off_q;
  logic [LANES-1:0][COEF_W-1:0] act_gain_d,  act_gain_q;
  logic [LANES-1:0][COEF_W-1:0] act_off_d,   act_off_q;
  logic                         act_full_d,  act_full_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane_regs
    localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(k);
    localparam logic [ADDR_W-1:0] OFF_ADDR  = ADDR_W'(LANES + k);

    always_comb begin
      pend_gain_d[k] = pend_gain_q[k];
      pend_off_d[k]  = pend_off_q[k];
      if (wr_en && (wr_addr == GAIN_ADDR)) pend_gain_d[k] = wr_data;
      if (wr_en && (wr_addr == OFF_ADDR))  pend_off_d[k]  = wr_data;
    end

    always_comb begin
      act_gain_d[k] = act_gain_q[k];
      act_off_d[k]  = act_off_q[k];
      if (boundary) begin
        act_gain_d[k] = pend_gain_q[k];
        act_off_d[k]  = pend_off_q[k];
      end
    end
  end

  always_comb act_full_d = boundary ? mode_in : act_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_gain_q <= {LANES{GAIN_ONE}};
      pend_off_q  <= '0;
      act_gain_q  <= {LANES{GAIN_ONE}};
      act_off_q   <= '0;
      act_full_q  <= 1'b1;
    end else begin
      pend_gain_q <= pend_gain_d;
      pend_off_q  <= pend_off_d;
      act_gain_q  <= act_gain_d;
      act_off_q   <= act_off_d;
      act_full_q  <= act_full_d;
    end
  end

  assign act_gain = act_gain_q;
  assign act_off  = act_off_q;
  assign act_full = act_full_q;

  // R8: the working set only moves on an accepted last sample
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_gain_q) && $stable(act_off_q) && $stable(act_full_q)));

endmodule

// File: rtl/pol_lane.sv
module pol_lane #(
  parameter int IN_W   = 16,
  parameter int COEF_W = 32,
  parameter int FRAC   = 16,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_s0,
  input  logic                     en_s1,
  input  logic                     en_s2,
  input  logic                     lane_on,
  input  logic signed [IN_W-1:0]   x,
  input  logic [COEF_W-1:0]        gain,
  input  logic signed [COEF_W-1:0] offset,
  output logic signed [OUT_W-1:0]  y,
  output logic                     sat_now
);

  localparam int SUM_W  = ((IN_W + FRAC) > COEF_W ? (IN_W + FRAC) : COEF_W) + 1;
  localparam int PROD_W = SUM_W + COEF_W + 1;
  localparam int SHIFT  = 2 * FRAC;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (SHIFT - 1);
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  // stage 1: offset add, gain captured alongside
  logic signed [SUM_W-1:0]  x_ext, off_ext, sum_d, sum_q;
  logic [COEF_W-1:0]        gain_q;
  // stage 2: multiply
  logic signed [PROD_W-1:0] prod_d, prod_q;
  // stage 3: round and clamp
  logic signed [PROD_W-1:0] rnd, scaled;
  logic signed [OUT_W-1:0]  y_d, y_q;

  always_comb begin
    x_ext   = SUM_W'(x) <<< FRAC;
    off_ext = SUM_W'(offset);
    sum_d   = lane_on ? (x_ext + off_ext) : '0;
  end

  always_comb prod_d = PROD_W'(sum_q) * PROD_W'($signed({1'b0, gain_q}));

  always_comb begin
    rnd     = prod_q + HALF;
    scaled  = rnd >>> SHIFT;
    sat_now = (scaled > MAXV) || (scaled < MINV);
    if (scaled > MAXV)      y_d = OUT_W'(MAXV);
    else if (scaled < MINV) y_d = OUT_W'(MINV);
    else                    y_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      gain_q <= '0;
    end else if (en_s0) begin
      sum_q  <= sum_d;
      gain_q <= gain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prod_q <= '0;
    else if (en_s1) prod_q <= prod_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     y_q <= '0;
    else if (en_s2) y_q <= y_d;
  end

  assign y = y_q;

  // R4: a saturating sample leaves as one of the two range limits
  assert_sat_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s2 && sat_now) |=> ((y_q == OUT_W'(MAXV)) || (y_q == OUT_W'(MINV))));

  // R9: a disabled lane produces a zero sum
  assert_off_lane_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s0 && !lane_on) |=> (sum_q == '0));

endmodule

// File: rtl/pol_scale_stage.sv
module pol_scale_stage
  import pol_scale_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int IN_W   = 16,
  parameter int COEF_W = 32,
  parameter int FRAC   = 16,
  parameter int OUT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   full_stokes,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [LANES*IN_W-1:0]  in_data,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [COEF_W-1:0]      wr_data,
  output logic                   out_valid,
  output logic                   out_last,
  output logic [LANES*OUT_W-1:0] out_data,
  output logic [LANES-1:0]       ovf_flags
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(2 * LANES);
  localparam int                BASE_LANES = LANES / 2;

  ctl_t                          ctl_in;
  ctl_t [PIPE_DEPTH-1:0]         ctl_stage;
  logic                          boundary;
  logic [LANES-1:0][COEF_W-1:0]  act_gain, act_off;
  logic                          act_full;
  logic [LANES-1:0]              sat_vec;
  logic [LANES-1:0]              clr_mask;
  logic [LANES-1:0]              ovf_d, ovf_q;

  always_comb begin
    ctl_in.valid = in_valid;
    ctl_in.last  = in_last;
    boundary     = in_valid & in_last;
  end

  pol_ctrl_pipe u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_in    (ctl_in),
    .ctl_stage (ctl_stage)
  );

  pol_cfg_regs #(
    .LANES  (LANES),
    .COEF_W (COEF_W),
    .FRAC   (FRAC),
    .ADDR_W (ADDR_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .boundary (boundary),
    .mode_in  (full_stokes),
    .act_gain (act_gain),
    .act_off  (act_off),
    .act_full (act_full)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam bit ALWAYS_ON = (k < BASE_LANES);
    logic lane_on;
    assign lane_on = act_full | ALWAYS_ON;

    pol_lane #(
      .IN_W   (IN_W),
      .COEF_W (COEF_W),
      .FRAC   (FRAC),
      .OUT_W  (OUT_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_s0   (in_valid),
      .en_s1   (ctl_stage[0].valid),
      .en_s2   (ctl_stage[1].valid),
      .lane_on (lane_on),
      .x       (in_data[k*IN_W +: IN_W]),
      .gain    (act_gain[k]),
      .offset  (act_off[k]),
      .y       (out_data[k*OUT_W +: OUT_W]),
      .sat_now (sat_vec[k])
    );
  end

  // sticky saturation flags; a new saturation wins over a clear
  always_comb begin
    clr_mask = (wr_en && (wr_addr == CLR_ADDR)) ? wr_data[LANES-1:0] : '0;
    ovf_d    = ovf_q & ~clr_mask;
    if (ctl_stage[1].valid) ovf_d = ovf_d | sat_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_flags = ovf_q;
  assign out_valid = ctl_stage[PIPE_DEPTH-1].valid;
  assign out_last  = ctl_stage[PIPE_DEPTH-1].last;

  // R10: fixed three-cycle latency for valid and last
  assert_latency_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  assert_latency_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);
  assert_latency_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |-> ##3 out_last);

  for (genvar k = 0; k < LANES; k++) begin : g_flag_chk
    // R5: a set flag stays set unless its clear bit is written
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[k] && !clr_mask[k]) |=> ovf_q[k]);
    // R6: a clear with no saturation removes the flag
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[k] && !(ctl_stage[1].valid && sat_vec[k])) |=> !ovf_q[k]);
  end

endmodule

// File: tb/test_pol_scale_stage.sv
module test_pol_scale_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_stokes;
  logic        in_valid, in_last;
  logic [63:0] in_data;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        out_valid, out_last;
  logic [31:0] out_data;
  logic [3:0]  ovf_flags;

  always #2 clk = ~clk;

  pol_scale_stage i_pol_scale_stage (
    .clk, .rst_n, .full_stokes, .in_valid, .in_last, .in_data,
    .wr_en, .wr_addr, .wr_data, .out_valid, .out_last, .out_data, .ovf_flags
  );

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  typedef struct packed {
    logic             v;
    logic             l;
    logic [3:0][7:0]  d;
    logic [3:0]       s;
  } stg_t;

  // bench reference state
  stg_t        h1, h2, e_out;
  logic [3:0]  m_flags;
  logic [31:0] m_gain_p [4];
  logic [31:0] m_gain_a [4];
  logic [31:0] m_off_p  [4];
  logic [31:0] m_off_a  [4];
  bit          m_full_a;

  // next-cycle stimulus
  bit          nx_v, nx_l, nx_wr, nx_mode;
  logic [3:0]  nx_addr;
  logic [31:0] nx_wd;
  logic [15:0] nx_x [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // R2/R3/R4 reference: offset, multiply, round half up, clamp
  function automatic logic [7:0] ref_lane(input logic signed [15:0] x,
      input logic [31:0] g, input logic signed [31:0] o, output bit sat);
    logic signed [79:0] s, p, r;
    s = (80'(x) <<< 16) + 80'(o);
    p = s * $signed({48'd0, g});
    r = (p + 80'sd2147483648) >>> 32;
    sat = 1'b0;
    if (r > 80'sd127) begin
      sat = 1'b1; return 8'sd127;
    end
    if (r < -80'sd128) begin
      sat = 1'b1; return -8'sd128;
    end
    return r[7:0];
  endfunction

  task automatic model_reset();
    h1 = '0; h2 = '0; e_out = '0; m_flags = '0; m_full_a = 1'b1;
    for (int k = 0; k < 4; k++) begin
      m_gain_p[k] = 32'h0001_0000; m_gain_a[k] = 32'h0001_0000;
      m_off_p[k] = '0; m_off_a[k] = '0;
    end
  endtask

  task automatic step();
    logic [3:0] clr;
    stg_t nw;
    @(negedge clk);
    chk(out_valid == e_out.v, "R10", "out_valid", out_valid, e_out.v);
    chk(out_last == e_out.l, "R10", "out_last", out_last, e_out.l);
    if (e_out.v)
      for (int k = 0; k < 4; k++)
        chk(out_data[8*k +: 8] == e_out.d[k], cur_req, $sformatf("lane%0d data", k),
            longint'($signed(out_data[8*k +: 8])), longint'($signed(e_out.d[k])));
    chk(ovf_flags == m_flags, (cur_req == "R6") ? "R6" : "R5", "ovf_flags",
        ovf_flags, m_flags);
    // drive
    in_valid = nx_v; in_last = nx_l; full_stokes = nx_mode;
    for (int k = 0; k < 4; k++) in_data[16*k +: 16] = nx_x[k];
    wr_en = nx_wr; wr_addr = nx_addr; wr_data = nx_wd;
    // advance reference by one rising edge
    clr = (nx_wr && nx_addr == 4'd8) ? nx_wd[3:0] : 4'd0;
    e_out = h2;
    m_flags = (m_flags & ~clr) | (h2.v ? h2.s : 4'd0);
    h2 = h1;
    nw = '0;
    nw.v = nx_v; nw.l = nx_v & nx_l;
    if (nx_v)
      for (int k = 0; k < 4; k++) begin
        bit sat;
        if (m_full_a || k < 2) begin
          nw.d[k] = ref_lane(nx_x[k], m_gain_a[k], m_off_a[k], sat);
          nw.s[k] = sat;
        end
      end
    h1 = nw;
    if (nx_v && nx_l) begin
      m_full_a = nx_mode;
      for (int k = 0; k < 4; k++) begin
        m_gain_a[k] = m_gain_p[k]; m_off_a[k] = m_off_p[k];
      end
    end
    if (nx_wr) begin
      if (nx_addr < 4)      m_gain_p[nx_addr[1:0]] = nx_wd;
      else if (nx_addr < 8) m_off_p[nx_addr[1:0]]  = nx_wd;
    end
    nx_v = 0; nx_l = 0; nx_wr = 0;
  endtask

  task automatic send(input int a, input int b, input int c, input int d, input bit last);
    nx_x[0] = 16'(a); nx_x[1] = 16'(b); nx_x[2] = 16'(c); nx_x[3] = 16'(d);
    nx_v = 1; nx_l = last;
    step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    nx_wr = 1; nx_addr = a; nx_wd = d;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 0; in_valid = 0; in_last = 0; in_data = '0; full_stokes = 1;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    nx_v = 0; nx_l = 0; nx_wr = 0; nx_mode = 1; nx_addr = '0; nx_wd = '0;
    for (int k = 0; k < 4; k++) nx_x[k] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state and identity defaults
    cur_req = "R1";
    idle(2);
    send(5, -7, 100, -128, 1);
    send(0, 1, -1, 127, 0);
    idle(4);

    // R2: gain 2.0 on lane 0, offset 1.5 on lane 1, offset -3.0 on lane 3
    cur_req = "R2";
    wr(4'd0, 32'h0002_0000);
    wr(4'd5, 32'h0001_8000);
    wr(4'd7, 32'hFFFD_0000);
    send(0, 0, 0, 0, 1);
    send(10, 3, 9, 20, 0);
    send(-10, -4, -9, 2, 1);
    idle(4);

    // R3: half gain on all lanes, odd inputs of both signs
    cur_req = "R3";
    for (int k = 0; k < 8; k++) wr(4'(k), (k < 4) ? 32'h0000_8000 : 32'd0);
    send(0, 0, 0, 0, 1);
    send(3, -3, 1, -1, 0);
    send(5, -5, 7, -7, 1);
    idle(4);

    // R4, R5: clamp both directions, flags set and stick
    cur_req = "R4";
    for (int k = 0; k < 4; k++) wr(4'(k), 32'h0001_0000);
    send(0, 0, 0, 0, 1);
    send(300, -300, 127, -128, 0);
    cur_req = "R5";
    send(1, 2, 3, 4, 1);
    idle(4);

    // R6: clear lane 0 only, then clear coinciding with a new saturation
    cur_req = "R6";
    wr(4'd8, 32'h0000_0001);
    idle(2);
    send(0, 500, 0, 0, 0);
    idle(1);
    nx_wr = 1; nx_addr = 4'd8; nx_wd = 32'h0000_000F;
    step();
    idle(3);
    wr(4'd8, 32'h0000_000F);
    idle(2);

    // R8: write mid-spectrum and at the last sample
    cur_req = "R8";
    send(10, 10, 10, 10, 0);
    wr(4'd0, 32'h0003_0000);
    send(10, 10, 10, 10, 0);
    nx_wr = 1; nx_addr = 4'd1; nx_wd = 32'h0004_0000;
    send(10, 10, 10, 10, 1);
    send(10, 10, 10, 10, 1);
    send(10, 10, 10, 10, 0);
    idle(4);

    // R9: switch to two lanes only at a boundary
    cur_req = "R9";
    nx_mode = 0;
    send(300, 1, 300, -300, 0);
    send(300, 1, 300, -300, 1);
    send(300, 1, 300, -300, 1);
    nx_mode = 1;
    send(2, 2, 400, 2, 0);
    send(2, 2, 400, 2, 1);
    send(2, 2, 9, 2, 0);
    idle(4);

    // R7: unused addresses change nothing
    cur_req = "R7";
    for (int a = 9; a < 16; a++) wr(4'(a), 32'h7FFF_FFFF);
    send(0, 0, 0, 0, 1);
    send(11, -12, 13, -14, 1);
    idle(4);

    // random mix
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      if (($urandom % 100) < 6) begin
        nx_wr = 1; nx_addr = 4'($urandom % 16);
        sel = int'($urandom % 4);
        if (nx_addr < 4)
          nx_wd = (sel == 0) ? 32'h0001_0000 : (sel == 1) ? 32'h0000_4000 :
                  (sel == 2) ? ($urandom & 32'h0003_FFFF) : $urandom;
        else if (nx_addr < 8)
          nx_wd = (sel == 3) ? $urandom : (($urandom & 32'h00FF_FFFF) - 32'h0080_0000);
        else
          nx_wd = $urandom;
      end
      if (($urandom % 100) < 8) nx_mode = ~nx_mode;
      nx_v = (($urandom % 4) != 0);
      nx_l = (($urandom % 10) == 0);
      for (int k = 0; k < 4; k++) begin
        sel = int'($urandom % 3);
        nx_x[k] = (sel == 0) ? 16'($urandom) : 16'(int'($urandom % 321) - 160);
      end
      step();
    end
    idle(4);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule